// File: doc/BRIEF.md
# Thread Issue Selector

This block decides, every clock cycle, which of several hardware threads hands its next instruction to a shared pipeline. Each thread keeps its own program counter inside the block, so moving from one thread to another saves and restores nothing. For each thread the block receives a ready flag, a short-stall flag (for example a data hazard) and a long-stall flag (for example a miss in the second cache level). It reports a registered valid bit, the chosen thread number and the program counter of the instruction to fetch. The chosen thread's counter then steps forward by one instruction.

A mode input selects between two policies, and it can change at run time. In interleaved mode the selector rotates to a different thread on every cycle and passes over stalled threads. In stall-switch mode the selector stays on one owner thread. It leaves that thread only when the thread reports a long stall. A short stall on the owner only stops issue for that cycle.

Top module: `thread_issue_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `issue_valid` is 0. Reset sets thread t's program counter to BOOT_BASE + t*BOOT_STRIDE (0 and 0x1000 by default) and makes thread NTHREADS-1 the last-issued thread and the stall-switch owner.
- R2: A thread is eligible when `thr_ready[t]` is 1 and both `short_stall[t]` and `long_stall[t]` are 0. Only an eligible thread is ever issued.
- R3: The outputs are registered. The decision made from the inputs and state of one cycle appears on the outputs after the next rising edge.
- R4: In interleaved mode (`mode_coarse` = 0) the issued thread is the first eligible one found by searching upward from the last-issued thread plus one, wrapping modulo NTHREADS. The last-issued thread itself is checked last.
- R5: In interleaved mode, whenever some other thread is eligible, the issued thread differs from the last-issued thread. Stalled threads are skipped, and the remaining eligible threads keep issuing.
- R6: In stall-switch mode (`mode_coarse` = 1), while the owner has no long stall, only the owner may issue. The state of every other thread has no effect.
- R7: In stall-switch mode, if the owner has no long stall but is not eligible (it is short-stalled or not ready), `issue_valid` is 0 and the owner does not change.
- R8: In stall-switch mode, when the owner reports a long stall, the first eligible thread after the owner in wrap-around order becomes the owner and issues in that same decision. If no such thread exists, `issue_valid` is 0 and the owner is kept.
- R9: When no thread may issue under the current mode, `issue_valid` is 0 and no program counter advances.
- R10: `issue_pc` is the issued thread's counter value before the increment. That thread's counter then grows by PC_STEP (4 by default), and the counters of the other threads are left unchanged.
- R11: A change of `mode_coarse` applies to the very next decision. It resets no program counter, and the last-issued thread becomes the stall-switch owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_coarse | input | 1 | 0: interleave every cycle; 1: switch only on long stall |
| thr_ready | input | NTHREADS | Per-thread instruction-available flag |
| short_stall | input | NTHREADS | Per-thread short stall (e.g. data hazard) |
| long_stall | input | NTHREADS | Per-thread long stall (e.g. deep cache miss) |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_tid | output | $clog2(NTHREADS) | Thread selected for issue |
| issue_pc | output | PC_W | Program counter of the issued instruction |

## Verification
On every cycle the assertions check these properties:
- an issued thread was eligible in the previous cycle;
- nothing issues when no thread was eligible;
- in stall-switch mode the owner is kept unless it reported a long stall, and is left when it did;
- in interleaved mode the thread rotates whenever an alternative existed;
- back-to-back issues from one thread step the counter by PC_STEP.

The bench's sweeps over all ready and stall combinations are the only evidence of the exact wrap-around search order, the per-thread reset counter values, counters kept across mode changes, and counters that stay frozen across idle cycles.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic {
    SW_INTERLEAVE = 1'b0,
    SW_ON_LONG    = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/tis_rr_pick.sv
// Wrap-around priority search: first set request after position 'base'.
module tis_rr_pick #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [NT-1:0] req,
  input  logic [TW-1:0] base,
  output logic          found,
  output logic [TW-1:0] idx
);
  int pos;

  always_comb begin
    found = 1'b0;
    idx   = base;
    pos   = 0;
    // Walk from the farthest candidate to the nearest so the nearest wins.
    for (int k = NT; k >= 1; k--) begin
      pos = (int'(base) + k) % NT;
      if (req[pos]) begin
        found = 1'b1;
        idx   = TW'(pos);
      end
    end
  end
endmodule

// File: rtl/tis_pc_bank.sv
// One program counter per thread; one advance port and one read port.
module tis_pc_bank #(
  parameter int          NT          = 4,
  parameter int          TW          = 2,
  parameter int          PC_W        = 32,
  parameter int unsigned PC_STEP     = 4,
  parameter int unsigned BOOT_BASE   = 0,
  parameter int unsigned BOOT_STRIDE = 32'h1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [TW-1:0]   adv_tid,
  input  logic [TW-1:0]   rd_tid,
  output logic [PC_W-1:0] rd_pc
);
  logic [PC_W-1:0] pc_q [NT];

  for (genvar g = 0; g < NT; g++) begin : g_thr
    localparam logic [PC_W-1:0] INIT_PC = PC_W'(BOOT_BASE + g * BOOT_STRIDE);
    always_ff @(posedge clk) begin
      if (rst)
        pc_q[g] <= INIT_PC;
      else if (adv && adv_tid == TW'(g))
        pc_q[g] <= pc_q[g] + PC_W'(PC_STEP);
    end
  end

  assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int          NTHREADS    = 4,
  parameter int          PC_W        = 32,
  parameter int unsigned PC_STEP     = 4,
  parameter int unsigned BOOT_BASE   = 0,
  parameter int unsigned BOOT_STRIDE = 32'h1000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_coarse,
  input  logic [NTHREADS-1:0]         thr_ready,
  input  logic [NTHREADS-1:0]         short_stall,
  input  logic [NTHREADS-1:0]         long_stall,
  output logic                        issue_valid,
  output logic [$clog2(NTHREADS)-1:0] issue_tid,
  output logic [PC_W-1:0]             issue_pc
);
  import tis_pkg::*;

  localparam int TW = $clog2(NTHREADS);
  localparam logic [TW-1:0] LAST_TID = TW'(NTHREADS - 1);

  sw_mode_e             mode;
  logic [NTHREADS-1:0]  elig;
  logic [TW-1:0]        anchor_q;   // last issued thread = stall-switch owner
  logic                 rr_found;
  logic [TW-1:0]        rr_idx;
  logic                 search;
  logic                 sel_v;
  logic [TW-1:0]        sel_tid;
  logic [PC_W-1:0]      sel_pc;

  assign mode = sw_mode_e'(mode_coarse);
  assign elig = thr_ready & ~short_stall & ~long_stall;

  tis_rr_pick #(.NT(NTHREADS), .TW(TW)) u_pick (
    .req   (elig),
    .base  (anchor_q),
    .found (rr_found),
    .idx   (rr_idx)
  );

  // Interleaved mode always searches; stall-switch mode searches only when
  // the owner is on a long stall, otherwise it issues the owner or pauses.
  always_comb begin
    search  = (mode == SW_INTERLEAVE) || long_stall[anchor_q];
    sel_v   = search ? rr_found : elig[anchor_q];
    sel_tid = search ? rr_idx   : anchor_q;
  end

  tis_pc_bank #(
    .NT(NTHREADS), .TW(TW), .PC_W(PC_W), .PC_STEP(PC_STEP),
    .BOOT_BASE(BOOT_BASE), .BOOT_STRIDE(BOOT_STRIDE)
  ) u_pcs (
    .clk     (clk),
    .rst     (rst),
    .adv     (sel_v),
    .adv_tid (sel_tid),
    .rd_tid  (sel_tid),
    .rd_pc   (sel_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= '0;
      anchor_q    <= LAST_TID;
    end else begin
      issue_valid <= sel_v;
      if (sel_v) begin
        issue_tid <= sel_tid;
        issue_pc  <= sel_pc;
        anchor_q  <= sel_tid;
      end
    end
  end
endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
  parameter int          NTHREADS = 4,
  parameter int          PC_W     = 32,
  parameter int unsigned PC_STEP  = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        mode_coarse,
  input logic [NTHREADS-1:0]         thr_ready,
  input logic [NTHREADS-1:0]         short_stall,
  input logic [NTHREADS-1:0]         long_stall,
  input logic                        issue_valid,
  input logic [$clog2(NTHREADS)-1:0] issue_tid,
  input logic [PC_W-1:0]             issue_pc
);
  localparam int TW = $clog2(NTHREADS);

  // Snapshot of what the design saw when it made the decision now visible.
  logic [NTHREADS-1:0] elig_d;
  logic [NTHREADS-1:0] long_d;
  logic                coarse_d;
  logic [TW-1:0]       owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_d   <= '0;
      long_d   <= '0;
      coarse_d <= 1'b0;
      owner_q  <= TW'(NTHREADS - 1);
    end else begin
      elig_d   <= thr_ready & ~short_stall & ~long_stall;
      long_d   <= long_stall;
      coarse_d <= mode_coarse;
      if (issue_valid) owner_q <= issue_tid;
    end
  end

  assert_only_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> elig_d[issue_tid]);

  assert_idle_when_none_R9: assert property (@(posedge clk) disable iff (rst)
    (elig_d == '0) |-> !issue_valid);

  assert_owner_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (coarse_d && !long_d[owner_q] && issue_valid) |-> (issue_tid == owner_q));

  assert_leave_on_long_R8: assert property (@(posedge clk) disable iff (rst)
    (coarse_d && long_d[owner_q] && issue_valid) |-> (issue_tid != owner_q));

  assert_rotate_R5: assert property (@(posedge clk) disable iff (rst)
    (!coarse_d && issue_valid && ($countones(elig_d & ~(NTHREADS'(1) << owner_q)) != 0))
      |-> (issue_tid != owner_q));

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && issue_tid == $past(issue_tid))
      |-> (issue_pc == $past(issue_pc) + PC_W'(PC_STEP)));
endmodule

bind thread_issue_sel tis_checker #(
  .NTHREADS(NTHREADS), .PC_W(PC_W), .PC_STEP(PC_STEP)
) u_chk (
  .clk(clk), .rst(rst), .mode_coarse(mode_coarse),
  .thr_ready(thr_ready), .short_stall(short_stall), .long_stall(long_stall),
  .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
);

// File: tb/sim_thread_issue_sel.sv
`timescale 1ns/1ps
module sim_thread_issue_sel;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_coarse = 1'b0;
  logic [NT-1:0] thr_ready   = '0;
  logic [NT-1:0] short_stall = '0;
  logic [NT-1:0] long_stall  = '0;
  logic          issue_valid;
  logic [1:0]    issue_tid;
  logic [31:0]   issue_pc;

  int vectors = 0;
  int fails   = 0;

  int unsigned m_pc [NT];
  int          m_anchor;
  logic        prev_mode;

  always #5 clk = ~clk;

  thread_issue_sel u0 (
    .clk(clk), .rst(rst), .mode_coarse(mode_coarse),
    .thr_ready(thr_ready), .short_stall(short_stall), .long_stall(long_stall),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drives inputs, predicts, and checks the
  // registered result one falling edge later (R3: one register stage).
  task automatic step(logic md, logic [NT-1:0] rd, logic [NT-1:0] sh,
                      logic [NT-1:0] lg, string force_tag);
    logic [NT-1:0] el;
    logic          ev;
    int            et;
    int unsigned   epc;
    string         tag;
    mode_coarse = md; thr_ready = rd; short_stall = sh; long_stall = lg;
    el = rd & ~sh & ~lg;
    ev = 1'b0; et = m_anchor;
    if (!md || lg[m_anchor]) begin
      for (int k = NT; k >= 1; k--)
        if (el[(m_anchor + k) % NT]) begin ev = 1'b1; et = (m_anchor + k) % NT; end
    end else if (el[m_anchor]) begin
      ev = 1'b1;
    end
    if (force_tag != "")        tag = force_tag;
    else if (md != prev_mode)   tag = "R11";
    else if (!ev)               tag = (md && !lg[m_anchor]) ? "R7" : "R9";
    else if (!md)               tag = (el != rd) ? "R5" : "R4";
    else                        tag = lg[m_anchor] ? "R8" : "R6";
    epc = m_pc[et];
    if (ev) begin m_pc[et] += 4; m_anchor = et; end
    prev_mode = md;
    @(negedge clk);
    chk({tag, " valid"}, 32'(issue_valid), 32'(ev));
    if (ev) begin
      chk({tag, " tid"}, 32'(issue_tid), 32'(et));
      chk({tag, " R10 pc"}, issue_pc, epc);
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) m_pc[t] = 32'h1000 * t;
    m_anchor  = NT - 1;
    prev_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(issue_valid), 32'd0);
    rst = 1'b0;
    // R1: first issues show each thread's reset counter, starting at thread 0.
    for (int t = 0; t < NT; t++) step(1'b0, 4'hF, 4'h0, 4'h0, "R1");
    // Exhaustive sweep, interleaved mode (R2, R4, R5, R9, R10).
    for (int i = 0; i < 4096; i++)
      step(1'b0, 4'(i), 4'(i >> 4), 4'(i >> 8), "");
    // Exhaustive sweep, stall-switch mode (R6, R7, R8).
    for (int i = 0; i < 4096; i++)
      step(1'b1, 4'(i), 4'(i >> 4), 4'(i >> 8), "");
    // Scrambled patterns with the mode toggling every three cycles (R11).
    for (int i = 0; i < 4096; i++) begin
      int v;
      v = (i * 1237 + 91) % 4096;
      step(1'((i / 3) % 2), 4'(v), 4'(v >> 4), 4'(v >> 8), "");
    end
    // R6: owner keeps issuing while others are ready; R8 then moves it.
    for (int k = 0; k < 6; k++) step(1'b1, 4'hF, 4'h0, 4'h0, "R6");
    step(1'b1, 4'hF, 4'h0, 4'(1 << m_anchor), "R8");
    step(1'b1, 4'hF, 4'(1 << m_anchor), 4'h0, "R7");
    step(1'b1, 4'hF, 4'h0, 4'hF, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule